// File: doc/BRIEF.md
# Biphasic Stimulation Phase Sequencer

This block is the digital controller for one channel of a current-mode biphasic neural stimulator. A trigger taken while the block is idle starts one stimulation cycle. The block first clears the charge integrator for one clock. It then walks through four phases in a fixed order: a cathodic pulse of a selectable width, an interphase pause, an anodic pulse and a compensation phase. The amplitude code and width select are captured at the trigger and held for the whole cycle. The held code drives the current DACs and the integrator capacitor bank.

The cathodic pulse and the interphase pause are timed by a counter. The anodic pulse has no fixed length. It runs until the integrator comparator changes from the level it held when the anodic phase began, which shows that the delivered charge has returned to zero. A timeout of four cathodic widths ends a pulse whose comparator never moves, and it sets a sticky flag. The compensation phase opens with a one-clock pulse that starts the external window check. It lasts until that check reports done.

Top module: `stim_phase_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no trigger, every switch enable, the integrator reset, the window-check pulse, the timeout flag and the DAC code are all 0.
- R2: A trigger sampled high while idle captures the amplitude code and width select. The integrator reset is then high for exactly one clock, and the cathodic enable rises on the clock that immediately follows it.
- R3: The cathodic enable stays high for W clocks, where W = BASE_CYC × 1, × 2 and × 4 for width select 0, 1 and 2. Select 3 is treated as × 4. With the default BASE_CYC of 500 at 5 MHz this gives 100, 200 and 400 µs.
- R4: After the cathodic phase there are exactly W/4 clocks in which no switch enable is high. The anodic enable then rises.
- R5: The comparator level is captured on the last interphase clock. The anodic enable falls on the first clock edge at which the comparator differs from that captured level. If the difference is first seen on the k-th anodic clock, the anodic enable is high for k clocks.
- R6: If no difference is seen within 4W anodic clocks, the anodic phase ends after exactly 4W clocks. The timeout flag then goes high and stays high until reset.
- R7: The compensation enable rises on the clock after the anodic enable falls. The window-check pulse is high only on the first compensation clock. Compensation ends on the edge at which the done input is sampled high.
- R8: At most one of the cathodic, anodic and compensation enables is high in any clock. The DAC output equals the captured code while any enable is high and is 0 otherwise, even if the amplitude input changes during the cycle.
- R9: A trigger that arrives while a cycle is in progress has no effect. The running cycle keeps its timing, and no further cycle follows it.
- R10: The integrator reset request input reaches the integrator reset output in the same clock only while the block is idle. During a cycle it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Starts a cycle when sampled high in idle |
| amp_i | input | AMP_W | Stimulation amplitude code |
| wsel_i | input | 2 | Cathodic width select |
| cmp_i | input | 1 | Integrator comparator output |
| int_rst_req_i | input | 1 | External integrator reset request |
| comp_done_i | input | 1 | Compensation window check finished |
| cath_en_o | output | 1 | Cathodic current switch enable |
| anod_en_o | output | 1 | Anodic current switch enable |
| comp_en_o | output | 1 | Compensation switch enable |
| int_rst_o | output | 1 | Integrator reset |
| dac_o | output | AMP_W | Code applied to the DACs and the capacitor bank |
| win_chk_o | output | 1 | One-clock start of the window check |
| timeout_o | output | 1 | Sticky anodic timeout flag |

## Verification
The bench drives a comparator toggle on the first anodic clock and on the last clock before the timeout. It also runs a cycle with no toggle at all. A design that sampled the comparator late, or counted the timeout one clock off, would show a wrong anodic length or a wrong flag. The bench uses width select 3 and changes the amplitude and width inputs in the middle of a cycle. A design that did not hold its captured values would show a wrong width or DAC code. Triggers and integrator reset requests sent during a cathodic phase are meant to expose a design that restarts itself or clears the integrator mid-pulse. A compensation phase that ends after a single clock checks that the window-check pulse and the done handshake still line up.

// File: rtl/stim_seq_pkg.sv
package stim_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_IRST,
    PH_CATH,
    PH_IPD,
    PH_ANOD,
    PH_COMP
  } phase_e;

  // cathodic width in clocks for a width select
  function automatic int unsigned cath_len(input logic [1:0] sel, input int unsigned base);
    case (sel)
      2'd0:    return base;
      2'd1:    return 2 * base;
      default: return 4 * base;
    endcase
  endfunction

  function automatic int unsigned ipd_len(input logic [1:0] sel, input int unsigned base);
    return cath_len(sel, base) / 4;
  endfunction

  function automatic int unsigned tmo_len(input logic [1:0] sel, input int unsigned base);
    return 4 * cath_len(sel, base);
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_o <= '0;
    else if (clr_i)          cnt_o <= '0;
    else if (cnt_o != '1)    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/seq_flip_det.sv
module seq_flip_det (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_i,
  input  logic lvl_i,
  output logic flip_o
);
  logic ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ref_q <= 1'b0;
    else if (cap_i) ref_q <= lvl_i;
  end

  assign flip_o = (lvl_i != ref_q);
endmodule

// File: rtl/stim_phase_seq.sv
module stim_phase_seq
  import stim_seq_pkg::*;
#(
  parameter int BASE_CYC = 500,
  parameter int AMP_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [AMP_W-1:0] amp_i,
  input  logic [1:0]       wsel_i,
  input  logic             cmp_i,
  input  logic             int_rst_req_i,
  input  logic             comp_done_i,
  output logic             cath_en_o,
  output logic             anod_en_o,
  output logic             comp_en_o,
  output logic             int_rst_o,
  output logic [AMP_W-1:0] dac_o,
  output logic             win_chk_o,
  output logic             timeout_o
);
  localparam int CNT_W = $clog2(16 * BASE_CYC + 1);

  phase_e           st_q, st_n;
  logic [1:0]       sel_q;
  logic [AMP_W-1:0] amp_q;
  logic             tmo_q;
  logic [CNT_W-1:0] cnt_w, lim_w;

  // named internal events
  logic last_w, flip_w, cap_w, clr_w, busy_w, irst_w;

  seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_w), .cnt_o(cnt_w)
  );

  seq_flip_det u_flip (
    .clk(clk), .rst_n(rst_n), .cap_i(cap_w), .lvl_i(cmp_i), .flip_o(flip_w)
  );

  always_comb begin
    case (st_q)
      PH_CATH: lim_w = CNT_W'(cath_len(sel_q, BASE_CYC));
      PH_IPD:  lim_w = CNT_W'(ipd_len(sel_q, BASE_CYC));
      PH_ANOD: lim_w = CNT_W'(tmo_len(sel_q, BASE_CYC));
      default: lim_w = CNT_W'(1);
    endcase
  end

  assign last_w = (cnt_w == lim_w - 1'b1);
  assign cap_w  = (st_q == PH_IPD) && last_w;
  assign busy_w = (st_q != PH_IDLE);
  assign irst_w = (st_q == PH_IRST);

  always_comb begin
    st_n = st_q;
    case (st_q)
      PH_IDLE: if (trig_i)      st_n = PH_IRST;
      PH_IRST:                  st_n = PH_CATH;
      PH_CATH: if (last_w)      st_n = PH_IPD;
      PH_IPD:  if (last_w)      st_n = PH_ANOD;
      PH_ANOD: if (flip_w || last_w) st_n = PH_COMP;
      PH_COMP: if (comp_done_i) st_n = PH_IDLE;
      default:                  st_n = PH_IDLE;
    endcase
  end

  assign clr_w = (st_n != st_q) || !busy_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      sel_q <= '0;
      amp_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      st_q <= st_n;
      if (!busy_w && trig_i) begin
        sel_q <= wsel_i;
        amp_q <= amp_i;
      end
      if (st_q == PH_ANOD && !flip_w && last_w) tmo_q <= 1'b1;
    end
  end

  assign cath_en_o = (st_q == PH_CATH);
  assign anod_en_o = (st_q == PH_ANOD);
  assign comp_en_o = (st_q == PH_COMP);
  assign int_rst_o = irst_w || (!busy_w && int_rst_req_i);
  assign dac_o     = (cath_en_o || anod_en_o || comp_en_o) ? amp_q : '0;
  assign win_chk_o = comp_en_o && (cnt_w == '0);
  assign timeout_o = tmo_q;

endmodule

// File: rtl/stim_seq_chk.sv
module stim_seq_chk #(
  parameter int AMP_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_i,
  input logic             cath_en_o,
  input logic             anod_en_o,
  input logic             comp_en_o,
  input logic             int_rst_o,
  input logic [AMP_W-1:0] dac_o,
  input logic             win_chk_o,
  input logic             timeout_o,
  input logic             flip_w,
  input logic             busy_w,
  input logic             irst_w
);
  logic any_en;
  assign any_en = cath_en_o || anod_en_o || comp_en_o;

  p_one_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cath_en_o, anod_en_o, comp_en_o}) <= 1);

  p_code_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_en && $past(any_en) |-> $stable(dac_o));

  p_irst_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cath_en_o) |-> $past(int_rst_o));

  p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(anod_en_o) |-> !$past(cath_en_o));

  p_flip_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    anod_en_o && flip_w |=> !anod_en_o && comp_en_o);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> timeout_o);

  p_win_in_comp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_chk_o |-> comp_en_o);

  p_trig_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w && trig_i |=> !irst_w);

  p_req_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w && !irst_w |-> !int_rst_o);
endmodule

bind stim_phase_seq stim_seq_chk #(.AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i),
  .cath_en_o(cath_en_o), .anod_en_o(anod_en_o), .comp_en_o(comp_en_o),
  .int_rst_o(int_rst_o), .dac_o(dac_o), .win_chk_o(win_chk_o),
  .timeout_o(timeout_o), .flip_w(flip_w), .busy_w(busy_w), .irst_w(irst_w)
);

// File: tb/sim_stim_phase_seq.sv
`timescale 1ns/1ps
module sim_stim_phase_seq;
  localparam int BASE = 40;

  logic clk = 0, rst_n = 0;
  logic trig = 0, cmp = 0, req = 0, done = 0;
  logic [5:0] amp = 0;
  logic [1:0] wsel = 0;
  logic cath, anod, comp, irst, win, tmo;
  logic [5:0] dac;

  always #5 clk = ~clk;

  stim_phase_seq #(.BASE_CYC(BASE), .AMP_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .amp_i(amp), .wsel_i(wsel),
    .cmp_i(cmp), .int_rst_req_i(req), .comp_done_i(done),
    .cath_en_o(cath), .anod_en_o(anod), .comp_en_o(comp), .int_rst_o(irst),
    .dac_o(dac), .win_chk_o(win), .timeout_o(tmo)
  );

  typedef struct {
    int w; int ipd; int anod; int tmo; int amp; int comp;
  } exp_t;

  exp_t sb[$];
  int nchk = 0, nfail = 0;
  bit sticky = 0, finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // width rule restated: 1x, 2x, 4x, 4x
  function automatic int width_of(input logic [1:0] s);
    return (s == 2'd0) ? BASE : (s == 2'd1) ? 2 * BASE : 4 * BASE;
  endfunction

  // monitor
  exp_t cur;
  bit in_gap = 0;
  int cnt_c = 0, cnt_g = 0, cnt_a = 0, cnt_p = 0;
  logic pc = 0, pa = 0, pp = 0, pir = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cath && !pc) begin
        if (sb.size() == 0) chk(0, "R9 unexpected cycle start", 1, 0);
        else cur = sb.pop_front();
        chk(pir == 1'b1, "R2 integrator reset before cathodic", pir, 1);
        cnt_c = 0;
      end
      if (cath) cnt_c++;
      if (!cath && pc) begin
        chk(cnt_c == cur.w, "R3 cathodic width", cnt_c, cur.w);
        in_gap = 1; cnt_g = 0;
      end
      if (in_gap && !anod) cnt_g++;
      if (anod && !pa) begin
        chk(cnt_g == cur.ipd, "R4 interphase length", cnt_g, cur.ipd);
        in_gap = 0; cnt_a = 0;
      end
      if (anod) cnt_a++;
      if (!anod && pa) begin
        chk(cnt_a == cur.anod, "R5 R6 anodic length", cnt_a, cur.anod);
        chk(tmo == cur.tmo[0], "R6 timeout flag", tmo, cur.tmo);
        chk(comp == 1'b1, "R7 compensation follows anodic", comp, 1);
      end
      if (comp && !pp) cnt_p = 0;
      if (comp) cnt_p++;
      if (!comp && pp) chk(cnt_p == cur.comp, "R7 compensation length", cnt_p, cur.comp);
      chk(win == (comp && !pp), "R7 window pulse", win, comp && !pp);
      chk($countones({cath, anod, comp}) <= 1, "R8 one switch", $countones({cath, anod, comp}), 1);
      chk(dac == ((cath || anod || comp) ? 6'(cur.amp) : 6'd0), "R8 dac code", dac,
          (cath || anod || comp) ? cur.amp : 0);
      pc = cath; pa = anod; pp = comp; pir = irst;
    end
  end

  // driver: pushes the expected cycle, then plays the stimulus
  task automatic run_cycle(input logic [1:0] sel, input logic [5:0] a, input int k, input int m, input bit poke);
    exp_t e;
    e.w = width_of(sel); e.ipd = e.w / 4;
    e.anod = (k == 0) ? 4 * e.w : k;
    if (k == 0) sticky = 1;
    e.tmo = sticky; e.amp = a; e.comp = m;
    sb.push_back(e);
    @(posedge clk); #1; wsel = sel; amp = a; trig = 1;
    @(posedge clk); #1; trig = 0; amp = ~a; wsel = ~sel;
    if (poke) begin
      do @(negedge clk); while (!cath);
      repeat (3) @(negedge clk);
      @(posedge clk); #1; trig = 1; req = 1;
      @(negedge clk);
      chk(irst == 1'b0, "R10 request ignored in cycle", irst, 0);
      @(posedge clk); #1; trig = 0; req = 0;
    end
    do @(negedge clk); while (!anod);
    if (k > 0) begin
      repeat (k - 1) @(negedge clk);
      cmp = ~cmp;
    end
    do @(negedge clk); while (!comp);
    repeat (m - 1) @(negedge clk);
    done = 1;
    do @(negedge clk); while (comp);
    done = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({cath, anod, comp, irst, win, tmo} == 6'b0 && dac == 0, "R1 reset outputs",
        {cath, anod, comp, irst, win, tmo}, 0);
    #2 rst_n = 1;
    repeat (2) @(negedge clk);
    chk({cath, anod, comp, irst, win, tmo} == 6'b0 && dac == 0, "R1 idle after reset",
        {cath, anod, comp, irst, win, tmo}, 0);
    @(posedge clk); #1 req = 1;
    @(negedge clk);
    chk(irst == 1'b1, "R10 request passes in idle", irst, 1);
    @(posedge clk); #1 req = 0;
    @(negedge clk);
    chk(irst == 1'b0, "R10 request released", irst, 0);

    run_cycle(2'd0, 6'h2A, 30, 5, 1);
    run_cycle(2'd1, 6'h3F, 1, 1, 0);
    run_cycle(2'd2, 6'h01, 4 * width_of(2'd2) - 1, 3, 1);
    chk(tmo == 1'b0, "R6 no timeout yet", tmo, 0);
    cmp = 1;
    run_cycle(2'd3, 6'h15, 0, 2, 0);
    run_cycle(2'd0, 6'h33, 10, 4, 0);
    repeat (20) @(negedge clk);
    chk(tmo == 1'b1, "R6 flag sticky", tmo, 1);
    chk(cath == 1'b0, "R9 no extra cycle", cath, 0);
    chk(sb.size() == 0, "R9 all cycles seen", sb.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule